// File: doc/BRIEF.md
# Byte-Addressed GPIO Register with Open-Drain Two-Wire Pin Control

This block keeps a 24-bit pin state split into three bytes: a sensed-input byte, an output byte and a direction byte. Software reaches the bytes one at a time over a small register bus with a 2-bit address and an 8-bit data path. Two bits of the output and direction bytes serve as a software-toggled, open-drain clock/data pair for an I2C or SMBus segment. Software builds every bus phase itself by writing these bits.

A write only counts when it changes the addressed byte. After such a write, the pad controls are recomputed. The data pin is driven to its output bit when its direction bit is set, and released otherwise. The clock pin follows its output bit only while its direction bit is set, and otherwise keeps its last level. The input byte is then cleared. After the sensed data line has passed through a synchronizer, bit 0 of the input byte is reloaded with its level. The pads never drive high. A driven 1 or a released pin is pulled up outside the block.

Top module: `gpio_bb_top`

## Requirements
- R1: After reset all three bytes read 0, and both `sda_drive_low` and `scl_drive_low` are 0 (released).
- R2: A read with `rd_en` high at a clock edge puts the addressed byte on `rdata` after that edge: address 0 gives the input byte, 1 the output byte and 2 the direction byte.
- R3: Address 3 holds no field. It reads 0, and a write to it changes no byte and no pad.
- R4: A write to address 0 (the input byte) is ignored. No byte changes and the input byte is not refreshed.
- R5: A write whose data equals the current contents of the addressed byte has no effect. The bytes and pads stay the same and the input byte is not refreshed.
- R6: A write that changes the output byte (address 1) or the direction byte (address 2) replaces that byte at the capturing edge.
- R7: At the edge that captures an effective write, `sda_drive_low` becomes 1 exactly when direction bit 0 is 1 and output bit 0 is 0. Otherwise the data pin is released.
- R8: At the edge that captures an effective write, if direction bit 1 is 1 then `scl_drive_low` becomes the inverse of output bit 1. While direction bit 1 is 0, `scl_drive_low` keeps its value.
- R9: An effective write clears the input byte at its capturing edge. SAMPLE_DELAY edges later (default 4), input bit 0 takes the synchronized level of `sda_sense`. Input bits 7:1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 2 | Byte address (0 input, 1 output, 2 direction, 3 empty) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| sda_sense | input | 1 | Sensed level of the data line |
| sda_drive_low | output | 1 | Pull the data line low when 1 |
| scl_drive_low | output | 1 | Pull the clock line low when 1 |

## Verification
Read data and both pad controls change at the edge that captures the request, so the bench compares them at the falling edge that follows. The monitor pops the expected read byte at the falling edge after it sees `rd_en` captured. The refreshed input bit needs SAMPLE_DELAY edges after the write edge. The bench reads right after a write to see the cleared byte, then waits six cycles before it reads the sampled value. In the bench, the sensed line is the wired-AND of the pad control and an emulated target that can hold the line low. This lets it tell a refresh apart from a stale value.

// File: rtl/gpio_bb_pkg.sv
package gpio_bb_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_IN   = 2'd0,
        ADDR_OUT  = 2'd1,
        ADDR_DIR  = 2'd2,
        ADDR_NONE = 2'd3
    } gpio_addr_e;

    typedef struct packed {
        logic [BYTE_W-1:0] dir;
        logic [BYTE_W-1:0] outp;
        logic [BYTE_W-1:0] inp;
    } gpio_state_t;
endpackage

// File: rtl/gpio_bb_sampler.sv
module gpio_bb_sampler #(
    parameter int SYNC_STAGES  = 2,
    parameter int SAMPLE_DELAY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_sense,
    input  logic start,
    output logic sample_stb,
    output logic sda_level
);
    localparam int CNT_W = $clog2(SAMPLE_DELAY + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CNT_W-1:0]       cnt;
    } samp_t;

    samp_t                  samp_d, samp_q;
    logic [SYNC_STAGES-1:0] sync_shift;

    generate
        if (SYNC_STAGES == 1) begin : g_one_stage
            assign sync_shift = sda_sense;
        end else begin : g_chain
            assign sync_shift = {samp_q.sync[SYNC_STAGES-2:0], sda_sense};
        end
    endgenerate

    always_comb begin
        samp_d      = samp_q;
        samp_d.sync = sync_shift;
        if (start) begin
            samp_d.cnt = CNT_W'(SAMPLE_DELAY);
        end else if (samp_q.cnt != '0) begin
            samp_d.cnt = samp_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q.sync <= '1;
            samp_q.cnt  <= '0;
        end else begin
            samp_q <= samp_d;
        end
    end

    assign sample_stb = (samp_q.cnt == CNT_W'(1)) && !start;
    assign sda_level  = samp_q.sync[SYNC_STAGES-1];
endmodule

// File: rtl/gpio_bb_pads.sv
module gpio_bb_pads import gpio_bb_pkg::*; #(
    parameter int SDA_BIT = 0,
    parameter int SCL_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eff_wr,
    input  logic [BYTE_W-1:0] out_next,
    input  logic [BYTE_W-1:0] dir_next,
    output logic              sda_drive_low,
    output logic              scl_drive_low
);
    typedef struct packed {
        logic sda_lvl;
        logic scl_lvl;
    } pad_t;

    pad_t pad_d, pad_q;

    always_comb begin
        pad_d = pad_q;
        if (eff_wr) begin
            pad_d.sda_lvl = dir_next[SDA_BIT] ? out_next[SDA_BIT] : 1'b1;
            if (dir_next[SCL_BIT]) begin
                pad_d.scl_lvl = out_next[SCL_BIT];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pad_q <= '{sda_lvl: 1'b1, scl_lvl: 1'b1};
        end else begin
            pad_q <= pad_d;
        end
    end

    assign sda_drive_low = !pad_q.sda_lvl;
    assign scl_drive_low = !pad_q.scl_lvl;
endmodule

// File: rtl/gpio_bb_regs.sv
module gpio_bb_regs import gpio_bb_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              sample_stb,
    input  logic              sda_level,
    output logic              eff_wr,
    output gpio_state_t       st_next,
    output gpio_state_t       st_cur,
    output logic [BYTE_W-1:0] rdata
);
    typedef struct packed {
        gpio_state_t       st;
        logic [BYTE_W-1:0] rdata;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        eff_wr = 1'b0;
        if (wr_en) begin
            case (addr)
                ADDR_OUT: begin
                    if (wdata != regs_q.st.outp) begin
                        eff_wr           = 1'b1;
                        regs_d.st.outp   = wdata;
                    end
                end
                ADDR_DIR: begin
                    if (wdata != regs_q.st.dir) begin
                        eff_wr           = 1'b1;
                        regs_d.st.dir    = wdata;
                    end
                end
                default: ;
            endcase
        end
        if (eff_wr) begin
            regs_d.st.inp = '0;
        end else if (sample_stb) begin
            regs_d.st.inp = {{(BYTE_W-1){1'b0}}, sda_level};
        end
        if (rd_en) begin
            case (addr)
                ADDR_IN:  regs_d.rdata = regs_q.st.inp;
                ADDR_OUT: regs_d.rdata = regs_q.st.outp;
                ADDR_DIR: regs_d.rdata = regs_q.st.dir;
                default:  regs_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign st_next = regs_d.st;
    assign st_cur  = regs_q.st;
    assign rdata   = regs_q.rdata;
endmodule

// File: rtl/gpio_bb_top.sv
module gpio_bb_top import gpio_bb_pkg::*; #(
    parameter int SDA_BIT      = 0,
    parameter int SCL_BIT      = 1,
    parameter int SYNC_STAGES  = 2,
    parameter int SAMPLE_DELAY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              sda_sense,
    output logic              sda_drive_low,
    output logic              scl_drive_low
);
    logic        eff_wr;
    logic        sample_stb;
    logic        sda_level;
    gpio_state_t st_next;
    gpio_state_t st_cur;

    logic [BYTE_W-1:0] in_byte;
    logic [BYTE_W-1:0] out_byte;
    logic [BYTE_W-1:0] dir_byte;

    gpio_bb_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .sample_stb (sample_stb),
        .sda_level  (sda_level),
        .eff_wr     (eff_wr),
        .st_next    (st_next),
        .st_cur     (st_cur),
        .rdata      (rdata)
    );

    gpio_bb_pads #(
        .SDA_BIT (SDA_BIT),
        .SCL_BIT (SCL_BIT)
    ) u_pads (
        .clk           (clk),
        .rst_n         (rst_n),
        .eff_wr        (eff_wr),
        .out_next      (st_next.outp),
        .dir_next      (st_next.dir),
        .sda_drive_low (sda_drive_low),
        .scl_drive_low (scl_drive_low)
    );

    gpio_bb_sampler #(
        .SYNC_STAGES  (SYNC_STAGES),
        .SAMPLE_DELAY (SAMPLE_DELAY)
    ) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_sense  (sda_sense),
        .start      (eff_wr),
        .sample_stb (sample_stb),
        .sda_level  (sda_level)
    );

    assign in_byte  = st_cur.inp;
    assign out_byte = st_cur.outp;
    assign dir_byte = st_cur.dir;
endmodule

// File: rtl/gpio_bb_checker.sv
module gpio_bb_checker #(
    parameter int BW      = 8,
    parameter int SDA_BIT = 0,
    parameter int SCL_BIT = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [1:0]    addr,
    input logic [BW-1:0] wdata,
    input logic [BW-1:0] in_byte,
    input logic [BW-1:0] out_byte,
    input logic [BW-1:0] dir_byte,
    input logic          sda_drive_low,
    input logic          scl_drive_low
);
    // R3: the empty address touches nothing
    a_r3_empty_addr_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd3) |=> ($stable(out_byte) && $stable(dir_byte)));

    // R4: the input byte address is not writable
    a_r4_input_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0) |=> ($stable(out_byte) && $stable(dir_byte)));

    // R5: rewriting the same output value changes neither state nor pads
    a_r5_same_value_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1 && wdata == out_byte) |=>
        ($stable(out_byte) && $stable(dir_byte) && $stable(sda_drive_low) && $stable(scl_drive_low)));

    // R6: a changing direction write lands in the byte
    a_r6_dir_replaced: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd2 && wdata != dir_byte) |=> (dir_byte == $past(wdata)));

    // R7: data pad pulled low only for a driven zero
    a_r7_sda_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
        sda_drive_low == (dir_byte[SDA_BIT] && !out_byte[SDA_BIT]));

    // R8: a driven clock pin mirrors its output bit
    a_r8_scl_follows: assert property (@(posedge clk) disable iff (!rst_n)
        dir_byte[SCL_BIT] |-> (scl_drive_low == !out_byte[SCL_BIT]));

    // R8: an undriven clock pin keeps its level
    a_r8_scl_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_byte[SCL_BIT] |-> $stable(scl_drive_low));

    // R9: only bit 0 of the input byte can be set
    a_r9_upper_inputs_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_byte >> 1) == '0);
endmodule

bind gpio_bb_top gpio_bb_checker #(
    .BW      (8),
    .SDA_BIT (SDA_BIT),
    .SCL_BIT (SCL_BIT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .addr          (addr),
    .wdata         (wdata),
    .in_byte       (in_byte),
    .out_byte      (out_byte),
    .dir_byte      (dir_byte),
    .sda_drive_low (sda_drive_low),
    .scl_drive_low (scl_drive_low)
);

// File: tb/gpio_bb_top_tb.sv
module gpio_bb_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       sda_sense;
    logic       sda_drive_low;
    logic       scl_drive_low;
    logic       target_hold = 1'b0;
    logic       rd_seen = 1'b0;
    bit         done = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } rd_item_t;
    rd_item_t sb_q[$];

    always #10 clk = ~clk;

    // wired-AND line with external pull-up
    assign sda_sense = !(sda_drive_low || target_hold);

    gpio_bb_top u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .rd_en         (rd_en),
        .addr          (addr),
        .wdata         (wdata),
        .rdata         (rdata),
        .sda_sense     (sda_sense),
        .sda_drive_low (sda_drive_low),
        .scl_drive_low (scl_drive_low)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        rd_item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        addr  = a;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pads(input logic exp_sda, input logic exp_scl, input string tag);
        check(sda_drive_low == exp_sda, {tag, " sda"}, sda_drive_low, exp_sda);
        check(scl_drive_low == exp_scl, {tag, " scl"}, scl_drive_low, exp_scl);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compares read data one edge after the request
    always @(posedge clk) rd_seen <= rd_en && rst_n;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R2 unexpected read", rdata, 0);
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                check(rdata == it.exp, it.tag, rdata, it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        pads(1'b0, 1'b0, "R1 reset pads");
        rd(2'd0, 8'h00, "R1 input byte");
        rd(2'd1, 8'h00, "R1 output byte");
        rd(2'd2, 8'h00, "R1 direction byte");
        rd(2'd3, 8'h00, "R3 empty address at reset");

        // R6 output write, pins still inputs
        wr(2'd1, 8'hA5);
        pads(1'b0, 1'b0, "R7 released while undriven");
        idle(6);
        rd(2'd0, 8'h01, "R9 released line sampled high");
        rd(2'd1, 8'hA5, "R6 output byte replaced");

        // drive both pins: data bit 1 -> released, clock bit 0 -> low
        wr(2'd2, 8'h03);
        pads(1'b0, 1'b1, "R8 clock driven low");
        rd(2'd0, 8'h00, "R9 input cleared at write");
        idle(6);
        rd(2'd0, 8'h01, "R9 input refreshed");
        rd(2'd2, 8'h03, "R2 direction byte read");

        // drive data low
        wr(2'd1, 8'hA4);
        pads(1'b1, 1'b1, "R7 data driven low");
        idle(6);
        rd(2'd0, 8'h00, "R9 low line sampled");

        // release clock direction: clock must hold low
        wr(2'd2, 8'h01);
        pads(1'b1, 1'b1, "R8 clock holds after direction clear");
        wr(2'd1, 8'hA6);
        pads(1'b1, 1'b1, "R8 clock ignores output while undriven");

        // drive clock again: now high -> released
        wr(2'd2, 8'h03);
        pads(1'b1, 1'b0, "R8 clock follows output bit");

        // all inputs again: data released, clock keeps released
        wr(2'd2, 8'h00);
        pads(1'b0, 1'b0, "R7 data released by direction");
        idle(6);
        rd(2'd0, 8'h01, "R9 sample after release");

        // R5 same-value writes while target holds the line low
        target_hold = 1'b1;
        wr(2'd1, 8'hA6);
        wr(2'd2, 8'h00);
        idle(6);
        rd(2'd0, 8'h01, "R5 no refresh on same value");
        pads(1'b0, 1'b0, "R5 pads unchanged");

        // effective write sees the held line
        wr(2'd1, 8'h07);
        idle(6);
        rd(2'd0, 8'h00, "R9 target-held line sampled");
        target_hold = 1'b0;
        idle(2);

        // R4 input address writes ignored, no resample
        wr(2'd0, 8'hFF);
        idle(6);
        rd(2'd0, 8'h00, "R4 input byte unchanged and not resampled");
        rd(2'd1, 8'h07, "R4 output byte unchanged");

        // R3 empty address
        wr(2'd3, 8'h5A);
        pads(1'b0, 1'b0, "R3 pads unchanged");
        rd(2'd3, 8'h00, "R3 empty address reads zero");
        rd(2'd1, 8'h07, "R3 output byte unchanged");
        rd(2'd2, 8'h00, "R3 direction byte unchanged");

        idle(3);
        check(sb_q.size() == 0, "R2 all reads returned", sb_q.size(), 0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule